// File: doc/BRIEF.md
# Alarm Wake-Up Power-On Controller

This block turns the real-time clock's alarm-match pulse into an active-low request that asks the system supply to switch the machine on. Its behaviour depends on whether the standby supply rail is present. While standby is present, a match raises the request only when the alarm wake enable is set. While standby is absent, the request is held inactive. If the remember enable is set at that time, a match is stored as a pending wake. The pending wake is replayed as soon as standby returns, whatever the value of the alarm wake enable.

The standby-present flag comes from another supply domain, so it passes through a synchronizer chain before any decision uses it. Once the request is asserted, it stays asserted until software writes the acknowledge strobe. The block does not sequence supplies and does not keep time. It only decides when the request line is driven low.

Top module: `wake_power_ctrl`

## Requirements
- R1: After reset, `powerOnN` is 1 (inactive) and no pending wake is stored.
- R2: With standby present (synchronized) and `alarmWakeEn` = 1, a one-cycle `alarmHit` drives `powerOnN` to 0 on the next rising clock edge.
- R3: With standby present and `alarmWakeEn` = 0, `alarmHit` has no effect and `powerOnN` stays 1.
- R4: An `alarmHit` that arrives while standby is absent and `rememberEn` = 1 is stored. When `standbyOk` rises, `powerOnN` goes to 0 on the third rising edge after the rise (two synchronizer stages plus the output register) and stays 1 before that edge.
- R5: The replay on standby return takes place when `alarmWakeEn` = 0, both at the time of the alarm and at the time of the return.
- R6: An `alarmHit` that arrives while standby is absent and `rememberEn` = 0 is dropped, and `powerOnN` stays 1 after standby returns.
- R7: Once `powerOnN` is 0, it stays 0 until `wakeAck` = 1 and returns to 1 on the next edge. If a new wake trigger comes in the same cycle as the acknowledge, the trigger wins and `powerOnN` stays 0.
- R8: A pending wake is cleared on the same edge that drives `powerOnN` low through a replay, so an acknowledged replay does not happen again.
- R9: While synchronized standby is absent, `powerOnN` is 1. When `standbyOk` falls while the request is active, `powerOnN` returns to 1 on the third rising edge after the fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| alarmHit | input | 1 | One-cycle pulse when the time matches the alarm |
| standbyOk | input | 1 | Standby supply present; asynchronous to clk |
| alarmWakeEn | input | 1 | Alarm wake enable, used while standby is present |
| rememberEn | input | 1 | Enable that stores an alarm missed while standby is absent |
| wakeAck | input | 1 | Software acknowledge strobe that releases the request |
| powerOnN | output | 1 | Active-low power-on request |

## Verification
A live alarm and an acknowledge each take effect one clock edge after the cycle in which they are presented. A change on `standbyOk` takes effect on the third edge, because it passes through two synchronizer flops and then the output register. The bench drives every input on the falling edge and counts the rising edges with falling-edge waits. It samples the request one edge before the result is due, to confirm the output has not yet changed, and again on the edge where it is due. Checks that something has no effect are taken after the stimulus and before the next scenario changes any input.

// File: rtl/wake_power_pkg.sv
package wake_power_pkg;

  // Strobes issued by the control to the state datapath each cycle.
  typedef struct packed {
    logic setPending;  // store a missed alarm
    logic clrPending;  // pending wake consumed by a replay
    logic fire;        // drive the request active
    logic ackRelease;  // software acknowledge
    logic forceOff;    // standby absent: request inactive
  } wakeStrobes_t;

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic qOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= dIn;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign qOut = chain[STAGES-1];

endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_power_pkg::*;
(
  input  logic         alarmHit,
  input  logic         standbySync,
  input  logic         alarmWakeEn,
  input  logic         rememberEn,
  input  logic         wakeAck,
  input  logic         pendingWake,
  output wakeStrobes_t strobes
);

  logic liveFire;
  logic replay;

  always_comb begin
    liveFire           = standbySync & alarmHit & alarmWakeEn;
    replay             = standbySync & pendingWake;  // ignores alarmWakeEn
    strobes.fire       = liveFire | replay;
    strobes.clrPending = replay;
    strobes.setPending = ~standbySync & alarmHit & rememberEn;
    strobes.ackRelease = wakeAck;
    strobes.forceOff   = ~standbySync;
  end

endmodule

// File: rtl/wake_dp.sv
module wake_dp
  import wake_power_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  wakeStrobes_t strobes,
  output logic         pendingWake,
  output logic         powerOnN
);

  logic wakeActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingWake <= 1'b0;
    end else if (strobes.setPending) begin
      pendingWake <= 1'b1;
    end else if (strobes.clrPending) begin
      pendingWake <= 1'b0;
    end
  end

  // Priority: standby loss, then trigger, then acknowledge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeActive <= 1'b0;
    end else if (strobes.forceOff) begin
      wakeActive <= 1'b0;
    end else if (strobes.fire) begin
      wakeActive <= 1'b1;
    end else if (strobes.ackRelease) begin
      wakeActive <= 1'b0;
    end
  end

  assign powerOnN = ~wakeActive;

endmodule

// File: rtl/wake_power_ctrl.sv
module wake_power_ctrl
  import wake_power_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic alarmHit,
  input  logic standbyOk,
  input  logic alarmWakeEn,
  input  logic rememberEn,
  input  logic wakeAck,
  output logic powerOnN
);

  logic         standbySync;
  logic         pendingWake;
  wakeStrobes_t strobes;

  wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (standbyOk),
    .qOut (standbySync)
  );

  wake_ctrl u_ctrl (
    .alarmHit    (alarmHit),
    .standbySync (standbySync),
    .alarmWakeEn (alarmWakeEn),
    .rememberEn  (rememberEn),
    .wakeAck     (wakeAck),
    .pendingWake (pendingWake),
    .strobes     (strobes)
  );

  wake_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .pendingWake (pendingWake),
    .powerOnN    (powerOnN)
  );

endmodule

// File: rtl/wake_power_ctrl_checker.sv
module wake_power_ctrl_checker (
  input logic clk,
  input logic rstN,
  input logic alarmHit,
  input logic alarmWakeEn,
  input logic wakeAck,
  input logic powerOnN,
  input logic standbySync,
  input logic pendingWake
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (powerOnN && !pendingWake));

  assert_live_fire_R2: assert property (@(posedge clk) disable iff (!rstN)
    (standbySync && alarmWakeEn && alarmHit) |=> !powerOnN);

  assert_masked_alarm_R3: assert property (@(posedge clk) disable iff (!rstN)
    (standbySync && !alarmWakeEn && !pendingWake && powerOnN) |=> powerOnN);

  assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!powerOnN && standbySync && !wakeAck) |=> !powerOnN);

  assert_ack_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wakeAck && standbySync && !pendingWake && !(alarmHit && alarmWakeEn)) |=> powerOnN);

  assert_replay_consumed_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pendingWake && standbySync) |=> (!pendingWake && !powerOnN));

  assert_absent_inactive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !standbySync |=> powerOnN);

endmodule

bind wake_power_ctrl wake_power_ctrl_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .alarmHit    (alarmHit),
  .alarmWakeEn (alarmWakeEn),
  .wakeAck     (wakeAck),
  .powerOnN    (powerOnN),
  .standbySync (standbySync),
  .pendingWake (pendingWake)
);

// File: tb/wake_power_ctrl_bench.sv
module wake_power_ctrl_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic alarmHit = 1'b0;
  logic standbyOk = 1'b1;
  logic alarmWakeEn = 1'b0;
  logic rememberEn = 1'b0;
  logic wakeAck = 1'b0;
  logic powerOnN;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  wake_power_ctrl u_wake_power_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .alarmHit    (alarmHit),
    .standbyOk   (standbyOk),
    .alarmWakeEn (alarmWakeEn),
    .rememberEn  (rememberEn),
    .wakeAck     (wakeAck),
    .powerOnN    (powerOnN)
  );

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectOut(input logic exp, input string req);
    vectors++;
    if (powerOnN !== exp) begin
      miscompares++;
      $display("FAIL %s: powerOnN actual %b expected %b at %0t", req, powerOnN, exp, $time);
    end
  endtask

  task automatic pulseAlarm();
    alarmHit = 1'b1;
    edges(1);
    alarmHit = 1'b0;
  endtask

  task automatic pulseAck();
    wakeAck = 1'b1;
    edges(1);
    wakeAck = 1'b0;
  endtask

  task automatic testReset();
    edges(4);
    expectOut(1'b1, "R1 idle after reset");
  endtask

  task automatic testLiveAlarm();
    alarmWakeEn = 1'b1;
    pulseAlarm();
    expectOut(1'b0, "R2 low one edge after match");
    edges(5);
    expectOut(1'b0, "R7 held low without ack");
    pulseAck();
    expectOut(1'b1, "R7 released one edge after ack");
    alarmWakeEn = 1'b0;
  endtask

  task automatic testMasked();
    alarmWakeEn = 1'b0;
    pulseAlarm();
    expectOut(1'b1, "R3 masked match");
    edges(4);
    expectOut(1'b1, "R3 masked match later");
  endtask

  task automatic testReplay(input logic aieDuring, input string req);
    standbyOk = 1'b0;
    edges(4);
    expectOut(1'b1, "R9 inactive while absent");
    rememberEn = 1'b1;
    alarmWakeEn = aieDuring;
    pulseAlarm();
    expectOut(1'b1, "R9 absent match stays high");
    edges(3);
    rememberEn = 1'b0;
    standbyOk = 1'b1;
    edges(2);
    expectOut(1'b1, "R4 not before third edge");
    edges(1);
    expectOut(1'b0, req);
    edges(3);
    expectOut(1'b0, "R7 replay held");
    pulseAck();
    expectOut(1'b1, "R7 replay released");
    edges(5);
    expectOut(1'b1, "R8 no second replay");
    alarmWakeEn = 1'b0;
  endtask

  task automatic testForgotten();
    standbyOk = 1'b0;
    edges(4);
    rememberEn = 1'b0;
    alarmWakeEn = 1'b1;
    pulseAlarm();
    edges(2);
    alarmWakeEn = 1'b0;
    standbyOk = 1'b1;
    edges(3);
    expectOut(1'b1, "R6 dropped alarm on return");
    edges(4);
    expectOut(1'b1, "R6 dropped alarm later");
  endtask

  task automatic testDropWhileActive();
    alarmWakeEn = 1'b1;
    pulseAlarm();
    alarmWakeEn = 1'b0;
    expectOut(1'b0, "R2 active before drop");
    standbyOk = 1'b0;
    edges(2);
    expectOut(1'b0, "R9 still low two edges after fall");
    edges(1);
    expectOut(1'b1, "R9 released third edge after fall");
    standbyOk = 1'b1;
    edges(6);
    expectOut(1'b1, "R8 nothing pending after return");
  endtask

  task automatic testAckCollision();
    alarmWakeEn = 1'b1;
    pulseAlarm();
    expectOut(1'b0, "R2 active before collision");
    alarmHit = 1'b1;
    wakeAck = 1'b1;
    edges(1);
    alarmHit = 1'b0;
    wakeAck = 1'b0;
    expectOut(1'b0, "R7 trigger wins over ack");
    alarmWakeEn = 1'b0;
    pulseAck();
    expectOut(1'b1, "R7 later ack releases");
  endtask

  initial begin
    edges(3);
    rstN = 1'b1;
    testReset();
    testLiveAlarm();
    testMasked();
    testReplay(1'b1, "R4 replay on third edge after return");
    testReplay(1'b0, "R5 replay with alarm enable clear");
    testForgotten();
    testDropWhileActive();
    testAckCollision();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule